// File: doc/BRIEF.md
# Load-Store Address and Extension Unit

This unit carries out a single memory access command against a word-addressed synchronous memory port. A one-cycle start strobe presents a command descriptor together with the base register value, an offset register value and the store data. The unit forms the offset from either a signed immediate or an offset register shifted left by 0 to 3. It adds the offset to the base and chooses between plain offset, pre-indexed and post-indexed addressing. It then issues one or two memory beats.

Narrow loads are pulled out of the addressed byte lanes and zero-extended or sign-extended. Narrow stores replicate their data across the word and enable only the addressed lanes. Indexed forms return an updated base value with a write enable that lines up with the done pulse. Commands that cannot be executed are rejected without any memory traffic. Decode, condition evaluation and the register file belong to the surrounding pipeline.

Top module: `lsu_agen`

## Requirements
- R1: The offset is `roff_i << shift_i` when `reg_off_i`=1, and the sign-extended `imm_i` otherwise. The memory word address is bits [ADDR_W-1:2] of `base_i`+offset in offset mode (`mode_i`=0) and in pre-indexed mode (`mode_i`=1). It is bits [ADDR_W-1:2] of the unmodified `base_i` in post-indexed mode (`mode_i`=2).
- R2: In offset mode with an immediate offset, a negative `imm_i` is outside the range 0 to 4095. Such a command is illegal.
- R3: Type codes are 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned halfword, 4 signed halfword and 5 doubleword. A byte store drives `mem_be_o`=1<<addr[1:0] with the data byte on all four lanes. A halfword store drives `mem_be_o`=3<<(2*addr[1]) with the halfword on both halves. Word and doubleword stores drive `mem_be_o`=4'hF, and all their stores ignore addr[1:0].
- R4: A load takes byte addr[1:0] or halfword addr[1] of the read word. Types 1 and 3 zero-extend this value to 32 bits, and types 2 and 4 sign-extend it. Word loads return the full word.
- R5: A store of type 2 or 4, a type code of 6 or 7, and a `mode_i` of 3 are all illegal.
- R6: In modes 1 and 2, `rn_i` equal to `rt_i` is illegal. For a doubleword in those modes, `rn_i` equal to `rt2_i` is also illegal. An illegal command makes no memory request. It raises `done_o` and `illegal_o` together for one cycle, one cycle after start, and gives no writeback.
- R7: In modes 1 and 2, `wb_en_o` rises with `done_o` and `wb_data_o` is `base_i`+offset, where the offset may be negative. Mode 0 gives no writeback.
- R8: A doubleword makes two consecutive beats. The first beat carries `sdata_i` or the `ld_data_o` result at the word address. The second beat carries `sdata2_i` or the `ld2_data_o` result at the word address + 1. The unit writes back once, and `done_o` comes one cycle after the second beat.
- R9: A single access requests the memory one cycle after start, and read data returns one cycle after the request. `done_o` is a one-cycle pulse one cycle after the last beat, with `ld_en_o` (and `ld2_en_o` for doublewords) on loads.
- R10: A start strobe that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| load_i | input | 1 | 1 load, 0 store |
| type_i | input | 3 | Access type code |
| mode_i | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| reg_off_i | input | 1 | Use shifted register offset |
| shift_i | input | 2 | Left shift of register offset |
| imm_i | input | IMM_W | Signed immediate offset |
| rn_i | input | IDX_W | Base register index |
| rt_i | input | IDX_W | First transfer register index |
| rt2_i | input | IDX_W | Second transfer register index |
| base_i | input | 32 | Base register value |
| roff_i | input | 32 | Offset register value |
| sdata_i | input | 32 | Store data, first register |
| sdata2_i | input | 32 | Store data, second register |
| busy_o | output | 1 | Command in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W-2 | Memory word address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after request |
| ld_en_o | output | 1 | First load result valid |
| ld_data_o | output | 32 | First load result |
| ld2_en_o | output | 1 | Second load result valid |
| ld2_data_o | output | 32 | Second load result |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 32 | Base writeback value |
| done_o | output | 1 | Command finished |
| illegal_o | output | 1 | Command rejected |

## Verification
The bench instantiates the unit with ADDR_W=12, which gives a 1024-word model memory, and keeps the defaults IMM_W=13 and IDX_W=4. With these widths, every byte lane, both halfword positions and both doubleword beats can be reached inside a small memory. Negative post-indexed immediates and immediate offsets at the 4095 limit are also covered. A 4-bit register index makes rn/rt clashes easy to produce for the illegal-command checks.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    T_WORD = 3'd0, T_UB = 3'd1, T_SB = 3'd2, T_UH = 3'd3, T_SH = 3'd4, T_DW = 3'd5
  } acc_t;

  typedef enum logic [1:0] {
    M_OFF = 2'd0, M_PRE = 2'd1, M_POST = 2'd2
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_B1, S_B2, S_FIN, S_BAD
  } st_t;
endpackage

// File: rtl/lsu_addr.sv
module lsu_addr
  import lsu_pkg::*;
#(
  parameter int IMM_W = 13,
  parameter int SH_W  = 2
) (
  input  logic [DW-1:0]    base_i,
  input  logic [DW-1:0]    roff_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             reg_off_i,
  input  logic [1:0]       mode_i,
  output logic [DW-1:0]    acc_o,
  output logic [DW-1:0]    wb_o,
  output logic             imm_bad_o
);
  logic [DW-1:0] off;
  logic [DW-1:0] sum;

  always_comb begin
    if (reg_off_i) off = roff_i << shift_i;
    else           off = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    sum       = base_i + off;
    acc_o     = (mode_i == M_POST) ? base_i : sum;
    wb_o      = sum;
    // plain offset form only takes a non-negative immediate
    imm_bad_o = !reg_off_i && (mode_i == M_OFF) && imm_i[IMM_W-1];
  end
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
(
  input  logic [2:0]    typ_i,
  input  logic [1:0]    lo_i,
  input  logic [DW-1:0] sdata_i,
  input  logic [DW-1:0] rdata_i,
  output logic [3:0]    be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] ld_o
);
  logic [DW-1:0] byte_w;
  logic [DW-1:0] half_w;

  always_comb begin
    byte_w = rdata_i >> {lo_i, 3'b000};
    half_w = rdata_i >> {lo_i[1], 4'b0000};
    case (typ_i)
      T_UB, T_SB: begin
        be_o    = 4'b0001 << lo_i;
        wdata_o = {4{sdata_i[7:0]}};
        ld_o    = (typ_i == T_SB) ? {{24{byte_w[7]}}, byte_w[7:0]} : {24'd0, byte_w[7:0]};
      end
      T_UH, T_SH: begin
        be_o    = 4'b0011 << {lo_i[1], 1'b0};
        wdata_o = {2{sdata_i[15:0]}};
        ld_o    = (typ_i == T_SH) ? {{16{half_w[15]}}, half_w[15:0]} : {16'd0, half_w[15:0]};
      end
      default: begin
        be_o    = 4'hF;
        wdata_o = sdata_i;
        ld_o    = rdata_i;
      end
    endcase
  end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 13,
  parameter int IDX_W  = 4,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [2:0]       type_i,
  input  logic [1:0]       mode_i,
  input  logic             reg_off_i,
  input  logic [1:0]       shift_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] rn_i,
  input  logic [IDX_W-1:0] rt_i,
  input  logic [IDX_W-1:0] rt2_i,
  input  logic [31:0]      base_i,
  input  logic [31:0]      roff_i,
  input  logic [31:0]      sdata_i,
  input  logic [31:0]      sdata2_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [WA_W-1:0]  mem_addr_o,
  output logic [3:0]       mem_be_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  output logic             ld_en_o,
  output logic [31:0]      ld_data_o,
  output logic             ld2_en_o,
  output logic [31:0]      ld2_data_o,
  output logic             wb_en_o,
  output logic [31:0]      wb_data_o,
  output logic             done_o,
  output logic             illegal_o
);
  st_t st_q, st_d;
  logic [2:0]    typ_q;
  logic          load_q, wb_q;
  logic [DW-1:0] acc_q, wbv_q, sd_q, sd2_q, lo_q;

  logic [DW-1:0] acc_c, wbv_c;
  logic          imm_bad, cmd_bad, accept;
  logic [3:0]    lane_be;
  logic [DW-1:0] lane_wd, lane_ld;

  lsu_addr #(.IMM_W(IMM_W), .SH_W(2)) u_addr (
    .base_i(base_i), .roff_i(roff_i), .shift_i(shift_i), .imm_i(imm_i),
    .reg_off_i(reg_off_i), .mode_i(mode_i),
    .acc_o(acc_c), .wb_o(wbv_c), .imm_bad_o(imm_bad)
  );

  lsu_lane u_lane (
    .typ_i(typ_q), .lo_i(acc_q[1:0]), .sdata_i(sd_q), .rdata_i(mem_rdata_i),
    .be_o(lane_be), .wdata_o(lane_wd), .ld_o(lane_ld)
  );

  always_comb begin
    cmd_bad = (type_i > T_DW) || (mode_i == 2'd3) || imm_bad
           || (!load_i && (type_i == T_SB || type_i == T_SH))
           || ((mode_i != M_OFF) && ((rn_i == rt_i) || (type_i == T_DW && rn_i == rt2_i)));
    accept  = start_i && (st_q == S_IDLE);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (accept) st_d = cmd_bad ? S_BAD : S_B1;
      S_B1:   st_d = (typ_q == T_DW) ? S_B2 : S_FIN;
      S_B2:   st_d = S_FIN;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      typ_q  <= 3'd0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
      acc_q  <= '0;
      wbv_q  <= '0;
      sd_q   <= '0;
      sd2_q  <= '0;
      lo_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        typ_q  <= type_i;
        load_q <= load_i;
        wb_q   <= (mode_i != M_OFF);
        acc_q  <= acc_c;
        wbv_q  <= wbv_c;
        sd_q   <= sdata_i;
        sd2_q  <= sdata2_i;
      end
      if (st_q == S_B2) lo_q <= mem_rdata_i;  // first beat's read word
    end
  end

  always_comb begin
    busy_o      = (st_q != S_IDLE);
    mem_req_o   = (st_q == S_B1) || (st_q == S_B2);
    mem_we_o    = mem_req_o && !load_q;
    mem_addr_o  = acc_q[ADDR_W-1:2] + ((st_q == S_B2) ? WA_W'(1) : WA_W'(0));
    mem_be_o    = mem_req_o ? lane_be : 4'h0;
    mem_wdata_o = (st_q == S_B2) ? sd2_q : lane_wd;
    done_o      = (st_q == S_FIN) || (st_q == S_BAD);
    illegal_o   = (st_q == S_BAD);
    ld_en_o     = (st_q == S_FIN) && load_q;
    ld2_en_o    = ld_en_o && (typ_q == T_DW);
    ld_data_o   = (typ_q == T_DW) ? lo_q : lane_ld;
    ld2_data_o  = (typ_q == T_DW) ? mem_rdata_i : '0;
    wb_en_o     = (st_q == S_FIN) && wb_q;
    wb_data_o   = wbv_q;
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_bad_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cmd_bad) |=> (done_o && illegal_o && !mem_req_o && !wb_en_o));
  a_r7_wb_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (done_o && !illegal_o));
  a_r3_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |->
      ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || $countones(mem_be_o) == 4));
  a_r8_beat2_next_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_B2) |-> (mem_req_o && mem_addr_o == $past(mem_addr_o) + WA_W'(1)));
  a_r10_no_req_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mem_req_o);
endmodule

// File: tb/sim_lsu_agen.sv
module sim_lsu_agen;
  localparam int ADDR_W = 12;
  localparam int IMM_W  = 13;
  localparam int IDX_W  = 4;
  localparam int WA_W   = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             start, load, reg_off;
  logic [2:0]       typ;
  logic [1:0]       mode, shift;
  logic [IMM_W-1:0] imm;
  logic [IDX_W-1:0] rn, rt, rt2;
  logic [31:0]      base, roff, sd, sd2;
  logic             busy, mreq, mwe, ld_en, ld2_en, wb_en, done, illegal;
  logic [WA_W-1:0]  maddr;
  logic [3:0]       mbe;
  logic [31:0]      mwd, mrd, ld_d, ld2_d, wb_d;

  lsu_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .load_i(load), .type_i(typ),
    .mode_i(mode), .reg_off_i(reg_off), .shift_i(shift), .imm_i(imm),
    .rn_i(rn), .rt_i(rt), .rt2_i(rt2), .base_i(base), .roff_i(roff),
    .sdata_i(sd), .sdata2_i(sd2), .busy_o(busy), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_be_o(mbe), .mem_wdata_o(mwd), .mem_rdata_i(mrd),
    .ld_en_o(ld_en), .ld_data_o(ld_d), .ld2_en_o(ld2_en), .ld2_data_o(ld2_d),
    .wb_en_o(wb_en), .wb_data_o(wb_d), .done_o(done), .illegal_o(illegal)
  );

  logic [31:0] mem [0:(1<<WA_W)-1];
  always_ff @(posedge clk) begin
    if (mreq) begin
      mrd <= mem[maddr];
      if (mwe)
        for (int b = 0; b < 4; b++)
          if (mbe[b]) mem[maddr][8*b +: 8] <= mwd[8*b +: 8];
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [2:0] t, input logic [1:0] lo, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*lo +: 8];
    h = w[16*lo[1] +: 16];
    case (t)
      3'd1: return {24'd0, b};
      3'd2: return {{24{b[7]}}, b};
      3'd3: return {16'd0, h};
      3'd4: return {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  // issue one command and follow it cycle by cycle against the model
  task automatic run(input string req, input logic l, input logic [2:0] t, input logic [1:0] m,
                     input logic ro, input logic [1:0] s, input int im,
                     input logic [3:0] n, input logic [3:0] r1, input logic [3:0] r2,
                     input logic [31:0] b, input logic [31:0] o,
                     input logic [31:0] d1, input logic [31:0] d2, input bit poke);
    logic [31:0] off, sum, acc, rd1, rd2, ebe, ewd;
    logic illeg;
    logic [WA_W-1:0] wa;
    off = ro ? (o << s) : 32'(im);
    sum = b + off;
    acc = (m == 2'd2) ? b : sum;
    wa  = acc[ADDR_W-1:2];
    illeg = (t > 3'd5) || (m == 2'd3) || (!ro && m == 2'd0 && im < 0)
         || (!l && (t == 3'd2 || t == 3'd4))
         || (m != 2'd0 && (n == r1 || (t == 3'd5 && n == r2)));
    case (t)
      3'd1, 3'd2: begin ebe = 32'(4'b0001 << acc[1:0]); ewd = {4{d1[7:0]}}; end
      3'd3, 3'd4: begin ebe = acc[1] ? 32'hC : 32'h3; ewd = {2{d1[15:0]}}; end
      default:    begin ebe = 32'hF; ewd = d1; end
    endcase
    @(negedge clk);
    start = 1'b1; load = l; typ = t; mode = m; reg_off = ro; shift = s;
    imm = IMM_W'(im); rn = n; rt = r1; rt2 = r2; base = b; roff = o; sd = d1; sd2 = d2;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    if (illeg) begin
      chk(req, "illegal", 32'(illegal), 32'd1);
      chk(req, "done", 32'(done), 32'd1);
      chk(req, "req", 32'(mreq), 32'd0);
      chk(req, "wb_en", 32'(wb_en), 32'd0);
    end else begin
      chk(req, "b1 req", 32'(mreq), 32'd1);
      chk(req, "b1 addr", 32'(maddr), 32'(wa));
      chk(req, "b1 we", 32'(mwe), 32'(!l));
      chk(req, "b1 done", 32'(done), 32'd0);
      if (!l) begin
        chk(req, "b1 be", 32'(mbe), ebe);
        chk(req, "b1 wdata", mwd, ewd);
      end
      rd1 = mem[wa];
      if (poke) begin  // R10: strobe with other operands while busy
        start = 1'b1; base = 32'h0000_0AA0; mode = 2'd0; reg_off = 1'b0; imm = '0;
        @(posedge clk); #1 start = 1'b0;
      end
      if (t == 3'd5) begin
        @(negedge clk);
        chk(req, "b2 req", 32'(mreq), 32'd1);
        chk(req, "b2 addr", 32'(maddr), 32'(wa + WA_W'(1)));
        chk(req, "b2 done", 32'(done), 32'd0);
        if (!l) begin
          chk(req, "b2 be", 32'(mbe), 32'hF);
          chk(req, "b2 wdata", mwd, d2);
        end
        rd2 = mem[wa + WA_W'(1)];
      end
      @(negedge clk);
      chk(req, "done", 32'(done), 32'd1);
      chk(req, "illegal", 32'(illegal), 32'd0);
      chk(req, "fin req", 32'(mreq), 32'd0);
      chk(req, "wb_en", 32'(wb_en), 32'(m != 2'd0));
      if (m != 2'd0) chk(req, "wb_data", wb_d, sum);
      chk(req, "ld_en", 32'(ld_en), 32'(l));
      chk(req, "ld2_en", 32'(ld2_en), 32'(l && t == 3'd5));
      if (l) begin
        chk(req, "ld_data", ld_d, (t == 3'd5) ? rd1 : ext(t, acc[1:0], rd1));
        if (t == 3'd5) chk(req, "ld2_data", ld2_d, rd2);
      end
    end
    @(negedge clk);
    chk(req, "after done", 32'(done), 32'd0);
    chk(req, "after busy", 32'(busy), 32'd0);
    chk(req, "after req", 32'(mreq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << WA_W); i++) mem[i] = 32'h80C0_7F01 ^ (i * 32'h0103_0507);
    start = 0; load = 0; typ = 0; mode = 0; reg_off = 0; shift = 0; imm = '0;
    rn = 0; rt = 0; rt2 = 0; base = 0; roff = 0; sd = 0; sd2 = 0;
    repeat (3) @(negedge clk);
    chk("R9", "reset done", 32'(done), 32'd0);
    chk("R9", "reset busy", 32'(busy), 32'd0);
    chk("R9", "reset req", 32'(mreq), 32'd0);
    chk("R7", "reset wb", 32'(wb_en), 32'd0);
    rst_n = 1'b1;

    // R1 R9: word load, immediate offset
    run("R1", 1, 3'd0, 2'd0, 0, 2'd0, 8, 4'd1, 4'd2, 4'd3, 32'h100, 0, 0, 0, 0);
    // R1 R3: word store, register offset shifted by 3
    run("R3", 0, 3'd0, 2'd0, 1, 2'd3, 0, 4'd1, 4'd2, 4'd3, 32'h0, 32'h40, 32'h80FF_7F01, 0, 0);
    // R4: narrow loads from 0x200 in every lane
    for (int lo = 0; lo < 4; lo++) begin
      run("R4", 1, 3'd1, 2'd0, 0, 2'd0, lo, 4'd1, 4'd2, 4'd3, 32'h200, 0, 0, 0, 0);
      run("R4", 1, 3'd2, 2'd0, 0, 2'd0, lo, 4'd1, 4'd2, 4'd3, 32'h200, 0, 0, 0, 0);
    end
    run("R4", 1, 3'd3, 2'd0, 0, 2'd0, 2, 4'd1, 4'd2, 4'd3, 32'h200, 0, 0, 0, 0);
    run("R4", 1, 3'd4, 2'd0, 0, 2'd0, 2, 4'd1, 4'd2, 4'd3, 32'h200, 0, 0, 0, 0);
    run("R4", 1, 3'd4, 2'd0, 1, 2'd1, 0, 4'd1, 4'd2, 4'd3, 32'h1FC, 32'h2, 0, 0, 0);
    // R3 R7: byte and halfword stores, pre-indexed writeback
    run("R3", 0, 3'd1, 2'd1, 0, 2'd0, 6, 4'd5, 4'd2, 4'd3, 32'h300, 0, 32'h0000_00C3, 0, 0);
    run("R3", 0, 3'd3, 2'd1, 1, 2'd2, 0, 4'd5, 4'd2, 4'd3, 32'h300, 32'h1, 32'h0000_9A5E, 0, 0);
    run("R4", 1, 3'd0, 2'd0, 0, 2'd0, 4, 4'd5, 4'd2, 4'd3, 32'h300, 0, 0, 0, 0);
    // R1 R7: post-indexed, negative immediate
    run("R7", 1, 3'd3, 2'd2, 0, 2'd0, -16, 4'd6, 4'd2, 4'd3, 32'h302, 0, 0, 0, 0);
    // R2 boundary: 4095 legal in offset form
    run("R2", 1, 3'd1, 2'd0, 0, 2'd0, 4095, 4'd1, 4'd2, 4'd3, 32'h0, 0, 0, 0, 0);
    // R8: doubleword store post-indexed then load back
    run("R8", 0, 3'd5, 2'd2, 0, 2'd0, -16, 4'd8, 4'd2, 4'd3, 32'h400, 0, 32'h1122_3344, 32'h5566_7788, 0);
    run("R8", 1, 3'd5, 2'd0, 0, 2'd0, 0, 4'd2, 4'd2, 4'd3, 32'h400, 0, 0, 0, 0);
    run("R8", 1, 3'd5, 2'd1, 1, 2'd2, 0, 4'd9, 4'd2, 4'd3, 32'h3F8, 32'h2, 0, 0, 0);
    // R5 R6 R2: illegal commands
    run("R5", 0, 3'd2, 2'd0, 0, 2'd0, 0, 4'd1, 4'd2, 4'd3, 32'h100, 0, 32'hFF, 0, 0);
    run("R5", 0, 3'd4, 2'd0, 0, 2'd0, 0, 4'd1, 4'd2, 4'd3, 32'h100, 0, 32'hFF, 0, 0);
    run("R5", 1, 3'd6, 2'd0, 0, 2'd0, 0, 4'd1, 4'd2, 4'd3, 32'h100, 0, 0, 0, 0);
    run("R5", 1, 3'd0, 2'd3, 0, 2'd0, 0, 4'd1, 4'd2, 4'd3, 32'h100, 0, 0, 0, 0);
    run("R6", 1, 3'd0, 2'd1, 0, 2'd0, 4, 4'd2, 4'd2, 4'd3, 32'h100, 0, 0, 0, 0);
    run("R6", 0, 3'd5, 2'd2, 0, 2'd0, 8, 4'd3, 4'd2, 4'd3, 32'h100, 0, 1, 2, 0);
    run("R2", 1, 3'd0, 2'd0, 0, 2'd0, -4, 4'd1, 4'd2, 4'd3, 32'h100, 0, 0, 0, 0);
    // R6: clash is fine in plain offset mode
    run("R6", 1, 3'd5, 2'd0, 0, 2'd0, 8, 4'd3, 4'd2, 4'd3, 32'h100, 0, 0, 0, 0);
    // R10: strobe during a doubleword is ignored
    run("R10", 1, 3'd5, 2'd1, 0, 2'd0, 16, 4'd7, 4'd2, 4'd3, 32'h500, 0, 0, 0, 1);
    run("R10", 0, 3'd0, 2'd0, 0, 2'd0, 12, 4'd7, 4'd2, 4'd3, 32'h500, 0, 32'hDEAD_BEEF, 0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule